// File: doc/BRIEF.md
# Serial-to-Parallel Driver with Per-Bit Polarity

This block converts a serial bit stream into a set of parallel drive lines. A shift register takes one new bit on every rising clock edge. Its full word can then be copied into one of two parallel registers: a data register or a polarity register. A select input chooses the target, and a transfer-enable input lets the copy happen. A serial output carries the last shift stage, so several of these blocks can be chained into a longer shift path.

Each drive line is the XNOR of its data bit and its polarity bit. The polarity register therefore sets the level of each line when its data bit is 1 and inverts that level when its data bit is 0. A blanking input forces every line to 1 XNOR polarity. That is simply the polarity bit, so blanking drives each line to its programmed idle level.

The usual sequence has three steps. First, shift in a polarity word and commit it with the select low. Next, shift in data words and commit each one with the select high. Then release the blanking input so that the data reaches the lines.

Top module: `sp_polarity_driver`

## Requirements
- R1: On every rising clock edge, each shift stage takes the value of the stage before it, and stage 1 (bit 0 of the internal word) takes `ser_in`.
- R2: `ser_out` always shows the last shift stage, so a bit entered at an edge appears on `ser_out` after WIDTH edges.
- R3: Shifting does not depend on `hold_n`, `sel_data` or `blank_n`: the bit sequence on `ser_out` is the same for any values of those inputs.
- R4: At an edge where `hold_n` is 1 and `sel_data` is 1, the data register takes the shift word as it stood just before that edge.
- R5: At an edge where `hold_n` is 1 and `sel_data` is 0, the polarity register takes the shift word as it stood just before that edge.
- R6: At an edge where `hold_n` is 0, both the data register and the polarity register keep their values.
- R7: While `blank_n` is 0, `drive_out` equals the polarity register.
- R8: While `blank_n` is 1, each `drive_out` bit equals the XNOR of its data bit and its polarity bit. For example, data 0x3C with polarity 0xB4 gives 0x77.
- R9: Shift stage i feeds bit i-1 of both registers and of `drive_out`. A word shifted in with its most significant bit first therefore lands unchanged.
- R10: A synchronous `rst` clears the shift register and both parallel registers. After reset, `drive_out` is all ones while `blank_n` is 1, all zeros while `blank_n` is 0, and `ser_out` is 0.
- R11: A transfer into one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and transfer clock; the rising edge is active |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into stage 1 |
| hold_n | input | 1 | 1 = copy the shift word at the edge; 0 = both registers hold |
| sel_data | input | 1 | 1 = the data register is the target; 0 = the polarity register is the target |
| blank_n | input | 1 | 0 = lines show polarity only; 1 = lines show data XNOR polarity |
| drive_out | output | WIDTH | Parallel drive lines |
| ser_out | output | 1 | Last shift stage, used for chaining |

## Verification
The bench commits a polarity word and then a data word whose values differ. A design that swapped the targets, or that also wrote the other register, would show a wrong value as soon as blanking is toggled. It shifts a new word with the transfer held off while it toggles the select and blanking inputs. A design that let those inputs gate shifting, or that leaked the shift word into a register, would change `ser_out` or the lines. It uses asymmetric words to expose a reversed bit order, and it checks the all-ones line state after reset, which a design that used XOR instead of XNOR would not produce.

// File: rtl/sp_drv_pkg.sv
`timescale 1ns/1ps
package sp_drv_pkg;
   // Index of each parallel register inside the register bank.
   typedef enum logic {
      BANK_POL  = 1'b0,
      BANK_DATA = 1'b1
   } bank_sel_e;

   localparam int NUM_BANKS = 2;

   // A line is at its polarity level when its data bit is 1 and inverted when it is 0.
   function automatic logic line_level(input logic data_bit, input logic pol_bit);
      return ~(data_bit ^ pol_bit);
   endfunction
endpackage

// File: rtl/spd_shift_chain.sv
`timescale 1ns/1ps
module spd_shift_chain #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_in,
   output logic [WIDTH-1:0] word_q,
   output logic             ser_out
);
   localparam int LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("spd_shift_chain: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= {word_q[LAST-1:0], ser_in};
   end

   assign ser_out = word_q[LAST];

   AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> word_q == {$past(word_q[LAST-1:0]), $past(ser_in)}); // R1

   AST_SEROUT_LAST: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ser_out == $past(word_q[LAST-1])); // R2

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> word_q == '0); // R10
endmodule

// File: rtl/spd_latch_bank.sv
`timescale 1ns/1ps
module spd_latch_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] word_in,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (wr_en) q <= word_in;
   end

   AST_BANK_WRITE: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> q == $past(word_in)); // R4

   AST_BANK_KEEP: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(q)); // R6
endmodule

// File: rtl/spd_output_mix.sv
`timescale 1ns/1ps
module spd_output_mix
   import sp_drv_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] pol_q,
   input  logic             blank_n,
   output logic [WIDTH-1:0] lines
);
   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_line
         // While blanking, the data bit is treated as 1.
         assign lines[b] = line_level(blank_n ? data_q[b] : 1'b1, pol_q[b]);
      end
   endgenerate
endmodule

// File: rtl/sp_polarity_driver.sv
`timescale 1ns/1ps
module sp_polarity_driver
   import sp_drv_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_in,
   input  logic             hold_n,
   input  logic             sel_data,
   input  logic             blank_n,
   output logic [WIDTH-1:0] drive_out,
   output logic             ser_out
);
   logic [WIDTH-1:0] shift_word;
   logic [NUM_BANKS-1:0][WIDTH-1:0] bank_q;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] pol_q;

   spd_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .ser_in  (ser_in),
      .word_q  (shift_word),
      .ser_out (ser_out)
   );

   genvar k;
   generate
      for (k = 0; k < NUM_BANKS; k++) begin : g_bank
         logic wr_en;
         assign wr_en = hold_n && (sel_data == k[0]);
         spd_latch_bank #(.WIDTH(WIDTH)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .word_in (shift_word),
            .q       (bank_q[k])
         );
      end
   endgenerate

   assign data_q = bank_q[BANK_DATA];
   assign pol_q  = bank_q[BANK_POL];

   spd_output_mix #(.WIDTH(WIDTH)) u_mix (
      .data_q  (data_q),
      .pol_q   (pol_q),
      .blank_n (blank_n),
      .lines   (drive_out)
   );

   AST_LOAD_DATA: assert property (@(posedge clk) disable iff (rst)
      (hold_n && sel_data) |=> data_q == $past(shift_word) && $stable(pol_q)); // R4

   AST_LOAD_POL: assert property (@(posedge clk) disable iff (rst)
      (hold_n && !sel_data) |=> pol_q == $past(shift_word) && $stable(data_q)); // R11

   AST_HOLD_BOTH: assert property (@(posedge clk) disable iff (rst)
      !hold_n |=> $stable(data_q) && $stable(pol_q)); // R6

   AST_BLANK_POL: assert property (@(posedge clk) disable iff (rst)
      !blank_n |-> drive_out == pol_q); // R7
endmodule

// File: tb/sp_polarity_driver_bench.sv
`timescale 1ns/1ps
module sp_polarity_driver_bench;
   localparam int W = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst, ser_in, hold_n, sel_data, blank_n;
   logic [W-1:0] drive_out;
   logic ser_out;

   int n_run  = 0;
   int n_fail = 0;
   logic [W-1:0] m_sr, m_data, m_pol;

   sp_polarity_driver #(.WIDTH(W)) u_sp_polarity_driver (
      .clk(clk), .rst(rst), .ser_in(ser_in), .hold_n(hold_n),
      .sel_data(sel_data), .blank_n(blank_n),
      .drive_out(drive_out), .ser_out(ser_out)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model_out();
      return blank_n ? ~(m_data ^ m_pol) : m_pol;
   endfunction

   // One edge: drive the inputs, update the model from the pre-edge state, check at the negedge.
   task automatic step(input logic s, input logic h, input logic sl, input logic b);
      ser_in = s; hold_n = h; sel_data = sl; blank_n = b;
      @(posedge clk);
      if (h) begin
         if (sl) m_data = m_sr;
         else    m_pol  = m_sr;
      end
      m_sr = {m_sr[W-2:0], s};
      @(negedge clk);
      chk("R8 model lines", drive_out, model_out());
      chk("R2 model serial", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_sr[W-1]});
   endtask

   task automatic shift_word(input logic [W-1:0] w);
      for (int i = W - 1; i >= 0; i--) step(w[i], 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_reset();
      rst = 1'b1; ser_in = 1'b1; hold_n = 1'b1; sel_data = 1'b1; blank_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_sr = '0; m_data = '0; m_pol = '0;
      #1;
      chk("R10 lines after reset", drive_out, 8'hFF);
      chk("R10 serial after reset", {7'b0, ser_out}, 8'h00);
      blank_n = 1'b0; #1;
      chk("R10 blanked after reset", drive_out, 8'h00);
      blank_n = 1'b1;
   endtask

   task automatic t_polarity();
      shift_word(8'hB4);
      step(1'b0, 1'b1, 1'b0, 1'b1);
      blank_n = 1'b0; #1;
      chk("R5 R9 R7 polarity commit", drive_out, 8'hB4);
      blank_n = 1'b1;
   endtask

   task automatic t_data();
      shift_word(8'h3C);
      step(1'b0, 1'b1, 1'b1, 1'b1);
      #1;
      chk("R4 R8 data commit", drive_out, 8'h77);
      blank_n = 1'b0; #1;
      chk("R11 polarity untouched", drive_out, 8'hB4);
      blank_n = 1'b1;
   endtask

   task automatic t_hold_shift();
      // The shift word is now 0x78; shifting 1s brings its bits 6..0 and then a 1 to ser_out.
      logic [W-1:0] prior = 8'h78;
      for (int i = 0; i < W; i++) begin
         step(1'b1, 1'b0, i[0], i[1]);
         chk("R3 serial unaffected", {7'b0, ser_out}, {7'b0, (i < W - 1) ? prior[W-2-i] : 1'b1});
         chk("R1 shift model", {7'b0, ser_out}, {7'b0, m_sr[W-1]});
      end
      blank_n = 1'b1; #1;
      chk("R6 data held", drive_out, 8'h77);
      blank_n = 1'b0; #1;
      chk("R6 polarity held", drive_out, 8'hB4);
      blank_n = 1'b1;
   endtask

   task automatic t_blank_toggle();
      for (int i = 0; i < 4; i++) begin
         blank_n = i[0]; #1;
         chk(i[0] ? "R8 active lines" : "R7 blanked lines", drive_out, i[0] ? 8'h77 : 8'hB4);
      end
      blank_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_polarity();
      t_data();
      t_hold_shift();
      t_blank_toggle();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule